// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block sits between a memory client and the command pins of a four-bank SDRAM. The client presents one request at a time: activate, read, write, precharge, refresh or mode-register load. Each request carries a bank number and an address word, which holds the row, the column or the opcode. The block holds the request with `req_ready_o` low until every minimum spacing to earlier commands has passed. It then accepts the request and puts the matching pin pattern on the command bus in the next cycle. In every other cycle after reset it drives no-operation.

The block keeps an open/closed flag for each bank. It also keeps down-counters for the row-cycle, activate-to-column, activate-to-precharge and precharge-recovery windows. Global counters cover the bank-to-bank activate spacing, the column-to-column spacing and the recovery after refresh or mode load. The parameter `SPEED` picks one of three cycle-count profiles. A request that makes no sense for the current bank state is still accepted at once, but it issues nothing and pulses `err_o`. Data transfer, refresh scheduling and power-up sequencing are left to other logic.

Top module: `sdram_cmd_seq`

## Requirements
- R1: A request accepted on a clock edge appears on the pins during the next cycle as {cs_n, ras_n, cas_n, we_n}. The patterns are: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000. The request code on `req_op_i` is 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load. Bank and address are passed to `cmd_ba_o` and `cmd_addr_o`, except for refresh, which drives zero.
- R2: While reset is asserted the pins show deselect (cs_n high). From then on, any cycle without an issued command shows no-operation (0111). After reset all banks are closed and `err_o` is low.
- R3: A read or write to a bank is accepted no sooner than tRCD cycles after that bank's activate. Two column commands may be accepted on consecutive cycles.
- R4: A precharge of an open bank is accepted no sooner than tRAS cycles after its activate.
- R5: An activate is accepted no sooner than tRP cycles after that bank closed, and no sooner than tRC cycles after the same bank's previous activate.
- R6: Activates to different banks are at least tRRD cycles apart.
- R7: A precharge with address bit 10 low closes only the addressed bank. With bit 10 high it closes every bank. Closed banks appear as 0 in `bank_open_o`, one bit per bank.
- R8: A read or write with address bit 10 high also closes its bank. It waits for tRAS of that bank as well as tRCD, and the bank's tRP window starts at the cycle it is accepted.
- R9: A read or write to a closed bank, an activate to an open bank, a refresh or mode load while any bank is open, and request codes 0 or 7 are all rejected. Each is accepted on the first cycle it is presented and issues nothing. `err_o` is high for one cycle while the pins show no-operation, and `bank_open_o` is unchanged.
- R10: A refresh or mode load waits until every bank has passed its tRC and tRP windows. After a refresh, nothing is accepted for tRC cycles. After a mode load, nothing is accepted for 2 cycles.
- R11: Timing profiles, listed as (tRC, tRAS, tRP, tRRD, tRCD), with column, write-recovery and write-to-precharge spacing all 1: SPEED 0 = (9,6,3,2,3), SPEED 1 = (7,5,2,2,2), SPEED 2 = (6,4,2,2,2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 3 | Request code |
| req_bank_i | input | BANK_W | Target bank |
| req_addr_i | input | ADDR_W | Row, column or opcode; bit 10 is the close/all flag |
| req_ready_o | output | 1 | Request is taken on this edge when valid |
| err_o | output | 1 | Previous accepted request was rejected |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_ba_o | output | BANK_W | Bank pins |
| cmd_addr_o | output | ADDR_W | Address pins |
| bank_open_o | output | 2**BANK_W | Open flag per bank |

## Verification
The assertions assume the client keeps a request stable while `req_ready_o` is low. They also assume the request inputs are known whenever `req_valid_i` is high, so that the readiness term sees a defined bank and code. The stimulus changes requests only just after a falling edge. It holds each request until the edge at which it is taken and then drops valid, so no request is withdrawn or altered while stalled. It drives one instance per speed profile with the same command script.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_MRS = 3'd6,
    OP_BAD = 3'd7
  } op_e;

  typedef struct packed {
    logic [3:0] rc;
    logic [3:0] ras;
    logic [3:0] rp;
    logic [3:0] rrd;
    logic [3:0] rcd;
    logic [3:0] ccd;
    logic [3:0] cdl;
    logic [3:0] rdl;
  } tim_t;

  localparam int unsigned MRD_CYC = 2;

  function automatic tim_t speed_tim(input int unsigned sel);
    tim_t t;
    t.ccd = 4'd1;
    t.cdl = 4'd1;
    t.rdl = 4'd1;
    t.rrd = 4'd2;
    case (sel)
      0: begin t.rc = 4'd9; t.ras = 4'd6; t.rp = 4'd3; t.rcd = 4'd3; end
      1: begin t.rc = 4'd7; t.ras = 4'd5; t.rp = 4'd2; t.rcd = 4'd2; end
      default: begin t.rc = 4'd6; t.ras = 4'd4; t.rp = 4'd2; t.rcd = 4'd2; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned RC    = 9,
  parameter int unsigned RAS   = 6,
  parameter int unsigned RP    = 3,
  parameter int unsigned RCD   = 3,
  parameter int unsigned RDL   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_go_i,
  input  logic col_go_i,
  input  logic wr_go_i,
  input  logic close_go_i,
  output logic open_o,
  output logic act_ok_o,
  output logic col_ok_o,
  output logic pre_ok_o
);

  localparam logic [CNT_W-1:0] RC_L  = CNT_W'(RC - 1);
  localparam logic [CNT_W-1:0] RAS_L = CNT_W'(RAS - 1);
  localparam logic [CNT_W-1:0] RP_L  = CNT_W'(RP - 1);
  localparam logic [CNT_W-1:0] RCD_L = CNT_W'(RCD - 1);
  localparam logic [CNT_W-1:0] RDL_L = CNT_W'(RDL - 1);

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] mx(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic             open_q, open_n;
  logic [CNT_W-1:0] act_q, act_n, col_q, col_n, pre_q, pre_n;

  always_comb begin
    open_n = open_q;
    act_n  = dec(act_q);
    col_n  = dec(col_q);
    pre_n  = dec(pre_q);
    if (act_go_i) begin
      open_n = 1'b1;
      act_n  = RC_L;
      col_n  = RCD_L;
      pre_n  = RAS_L;
    end
    if (wr_go_i) pre_n = mx(pre_n, RDL_L);
    if (close_go_i) begin
      open_n = 1'b0;
      act_n  = mx(act_n, RP_L);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      act_q  <= '0;
      col_q  <= '0;
      pre_q  <= '0;
    end else begin
      open_q <= open_n;
      act_q  <= act_n;
      col_q  <= col_n;
      pre_q  <= pre_n;
    end
  end

  assign open_o   = open_q;
  assign act_ok_o = !open_q && (act_q == '0);
  assign col_ok_o = open_q && (col_q == '0);
  assign pre_ok_o = !open_q || (pre_q == '0);

  a_r3_col_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_go_i |-> (open_q && col_q == '0));
  a_r5_act_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_go_i |-> (!open_q && act_q == '0));
  a_r4_pre_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_go_i |-> (pre_q == '0));

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_seq_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  op_e               op_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [3:0]        pins_q;
  logic [BANK_W-1:0] ba_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= 4'b1111;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      pins_q <= 4'b0111;
      ba_q   <= '0;
      addr_q <= '0;
      if (issue_i) begin
        ba_q   <= ba_i;
        addr_q <= addr_i;
        case (op_i)
          OP_ACT:  pins_q <= 4'b0011;
          OP_RD:   pins_q <= 4'b0101;
          OP_WR:   pins_q <= 4'b0100;
          OP_PRE:  pins_q <= 4'b0010;
          OP_REF:  begin pins_q <= 4'b0001; ba_q <= '0; addr_q <= '0; end
          OP_MRS:  pins_q <= 4'b0000;
          default: pins_q <= 4'b0111;
        endcase
      end
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned SPEED  = 0,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned AP_BIT = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [2:0]               req_op_i,
  input  logic [BANK_W-1:0]        req_bank_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  output logic                     req_ready_o,
  output logic                     err_o,
  output logic                     cmd_cs_n_o,
  output logic                     cmd_ras_n_o,
  output logic                     cmd_cas_n_o,
  output logic                     cmd_we_n_o,
  output logic [BANK_W-1:0]        cmd_ba_o,
  output logic [ADDR_W-1:0]        cmd_addr_o,
  output logic [(1<<BANK_W)-1:0]   bank_open_o
);

  localparam int unsigned NB    = 1 << BANK_W;
  localparam int unsigned CNT_W = 4;
  localparam tim_t        TIM   = speed_tim(SPEED);
  localparam logic [CNT_W-1:0] RRD_L = CNT_W'(TIM.rrd - 1);
  localparam logic [CNT_W-1:0] COL_L = CNT_W'(((TIM.ccd > TIM.cdl) ? TIM.ccd : TIM.cdl) - 1);
  localparam logic [CNT_W-1:0] REF_L = CNT_W'(TIM.rc - 1);
  localparam logic [CNT_W-1:0] MRS_L = CNT_W'(MRD_CYC - 1);

  op_e            op;
  logic           ap, is_col, illegal, timing_ok, fire, issue;
  logic [NB-1:0]  sel, open_v, act_ok, col_ok, pre_ok;
  logic [NB-1:0]  act_go, col_go, wr_go, close_go;
  logic [CNT_W-1:0] rrd_q, colg_q, glob_q;
  logic           err_q;

  assign op     = op_e'(req_op_i);
  assign ap     = req_addr_i[AP_BIT];
  assign is_col = (op == OP_RD) || (op == OP_WR);

  always_comb begin
    sel = '0;
    sel[req_bank_i] = 1'b1;
  end

  always_comb begin
    case (op)
      OP_ACT:          illegal = open_v[req_bank_i];
      OP_RD, OP_WR:    illegal = !open_v[req_bank_i];
      OP_PRE:          illegal = 1'b0;
      OP_REF, OP_MRS:  illegal = |open_v;
      default:         illegal = 1'b1;
    endcase
  end

  always_comb begin
    case (op)
      OP_ACT:         timing_ok = act_ok[req_bank_i] && rrd_q == '0 && glob_q == '0;
      OP_RD, OP_WR:   timing_ok = col_ok[req_bank_i] && colg_q == '0 && glob_q == '0 &&
                                  (!ap || pre_ok[req_bank_i]);
      OP_PRE:         timing_ok = glob_q == '0 && (ap ? &pre_ok : pre_ok[req_bank_i]);
      OP_REF, OP_MRS: timing_ok = &act_ok && glob_q == '0;
      default:        timing_ok = 1'b0;
    endcase
  end

  assign req_ready_o = illegal || timing_ok;
  assign fire        = req_valid_i && req_ready_o;
  assign issue       = fire && !illegal;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign act_go[b]   = issue && op == OP_ACT && sel[b];
    assign col_go[b]   = issue && is_col && sel[b];
    assign wr_go[b]    = issue && op == OP_WR && sel[b];
    assign close_go[b] = issue && open_v[b] &&
                         ((op == OP_PRE && (ap || sel[b])) || (is_col && ap && sel[b]));

    sdram_bank_timer #(
      .CNT_W(CNT_W), .RC(int'(TIM.rc)), .RAS(int'(TIM.ras)), .RP(int'(TIM.rp)),
      .RCD(int'(TIM.rcd)), .RDL(int'(TIM.rdl))
    ) u_tmr (
      .clk_i, .rst_ni,
      .act_go_i(act_go[b]), .col_go_i(col_go[b]), .wr_go_i(wr_go[b]),
      .close_go_i(close_go[b]),
      .open_o(open_v[b]), .act_ok_o(act_ok[b]), .col_ok_o(col_ok[b]), .pre_ok_o(pre_ok[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q  <= '0;
      colg_q <= '0;
      glob_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q  <= fire && illegal;
      rrd_q  <= (issue && op == OP_ACT) ? RRD_L : (rrd_q == '0 ? rrd_q : rrd_q - 1'b1);
      colg_q <= (issue && is_col)       ? COL_L : (colg_q == '0 ? colg_q : colg_q - 1'b1);
      if (issue && op == OP_REF)      glob_q <= REF_L;
      else if (issue && op == OP_MRS) glob_q <= MRS_L;
      else if (glob_q != '0)          glob_q <= glob_q - 1'b1;
    end
  end

  sdram_cmd_enc #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_enc (
    .clk_i, .rst_ni,
    .issue_i(issue), .op_i(op), .ba_i(req_bank_i), .addr_i(req_addr_i),
    .cs_n_o(cmd_cs_n_o), .ras_n_o(cmd_ras_n_o), .cas_n_o(cmd_cas_n_o), .we_n_o(cmd_we_n_o),
    .ba_o(cmd_ba_o), .addr_o(cmd_addr_o)
  );

  assign err_o       = err_q;
  assign bank_open_o = open_v;

  a_r9_err_is_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!cmd_cs_n_o && cmd_ras_n_o && cmd_cas_n_o && cmd_we_n_o));
  a_r7_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && op == OP_PRE && ap) |=> (bank_open_o == '0));
  a_r10_ref_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && (op == OP_REF || op == OP_MRS)) |-> (bank_open_o == '0));
  a_r6_rrd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && op == OP_ACT) |-> (rrd_q == '0));

endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000,
                         P_NOP = 4'b0111;

  int TRC [NP] = '{9, 7, 6};
  int TRAS[NP] = '{6, 5, 4};
  int TRP [NP] = '{3, 2, 2};
  int TRRD[NP] = '{2, 2, 2};
  int TRCD[NP] = '{3, 2, 2};

  logic clk = 0;
  logic rst_n = 0;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;

  logic        req_valid [NP];
  logic [2:0]  req_op    [NP];
  logic [1:0]  req_bank  [NP];
  logic [12:0] req_addr  [NP];
  logic [NP-1:0] rdy, err, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  c_ba   [NP];
  logic [12:0] c_addr [NP];
  logic [3:0]  b_open [NP];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar p = 0; p < NP; p++) begin : g_dut
    sdram_cmd_seq #(.SPEED(p)) u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid[p]), .req_op_i(req_op[p]), .req_bank_i(req_bank[p]),
      .req_addr_i(req_addr[p]), .req_ready_o(rdy[p]), .err_o(err[p]),
      .cmd_cs_n_o(cs_n[p]), .cmd_ras_n_o(ras_n[p]), .cmd_cas_n_o(cas_n[p]),
      .cmd_we_n_o(we_n[p]), .cmd_ba_o(c_ba[p]), .cmd_addr_o(c_addr[p]),
      .bank_open_o(b_open[p])
    );
  end

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [3:0] pins(int p);
    return {cs_n[p], ras_n[p], cas_n[p], we_n[p]};
  endfunction

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // caller is just after a falling edge; returns just after the falling edge following acceptance
  task automatic issue(int p, logic [2:0] op, logic [1:0] b, logic [12:0] a, output int t);
    req_valid[p] = 1'b1; req_op[p] = op; req_bank[p] = b; req_addr[p] = a;
    #1;
    while (!rdy[p]) begin
      @(negedge clk); #1;
      chk("R2 idle nop", int'(pins(p)), int'(P_NOP));
    end
    @(posedge clk);
    @(negedge clk);
    t = cyc;
    req_valid[p] = 1'b0;
    #1;
  endtask

  task automatic chk_err(int p, string r, int t, int t_prev, logic [3:0] bo);
    chk({r, " accepted at once"}, t - t_prev, 1);
    chk({r, " err"}, int'(err[p]), 1);
    chk({r, " nop"}, int'(pins(p)), int'(P_NOP));
    chk({r, " banks unchanged"}, int'(b_open[p]), int'(bo));
  endtask

  task automatic run_prof(int p);
    int t_a0, t_rd, t_wr, t_p0, t_a0b, t_a1, t_e, t_p1, t_pa, t_ref, t_mrs, t_a3, t_ap, t_x;
    issue(p, 3'd1, 2'd0, 13'h123, t_a0);
    chk("R1 act pins", int'(pins(p)), int'(P_ACT));
    chk("R1 act addr", int'(c_addr[p]), 'h123);
    chk("R1 act open", int'(b_open[p]), 1);
    issue(p, 3'd2, 2'd0, 13'h010, t_rd);
    chk("R3 R11 act-to-read gap", t_rd - t_a0, TRCD[p]);
    chk("R1 read pins", int'(pins(p)), int'(P_RD));
    issue(p, 3'd3, 2'd0, 13'h020, t_wr);
    chk("R3 column gap", t_wr - t_rd, 1);
    chk("R1 write pins", int'(pins(p)), int'(P_WR));
    chk("R2 err low", int'(err[p]), 0);
    issue(p, 3'd4, 2'd0, 13'h000, t_p0);
    chk("R4 act-to-pre gap", t_p0 - t_a0, TRAS[p]);
    chk("R1 pre pins", int'(pins(p)), int'(P_PRE));
    chk("R7 single close", int'(b_open[p]), 0);
    issue(p, 3'd1, 2'd0, 13'h044, t_a0b);
    chk("R5 reopen gap", t_a0b, imax(t_p0 + TRP[p], t_a0 + TRC[p]));
    issue(p, 3'd1, 2'd1, 13'h055, t_a1);
    chk("R6 bank-to-bank gap", t_a1 - t_a0b, TRRD[p]);
    chk("R6 both open", int'(b_open[p]), 3);
    issue(p, 3'd1, 2'd1, 13'h000, t_e);
    chk_err(p, "R9 act open bank", t_e, t_a1, 4'b0011);
    t_x = t_e;
    issue(p, 3'd2, 2'd2, 13'h000, t_e);
    chk_err(p, "R9 read closed bank", t_e, t_x, 4'b0011);
    t_x = t_e;
    issue(p, 3'd5, 2'd0, 13'h000, t_e);
    chk_err(p, "R9 refresh while open", t_e, t_x, 4'b0011);
    t_x = t_e;
    issue(p, 3'd7, 2'd0, 13'h000, t_e);
    chk_err(p, "R9 reserved code", t_e, t_x, 4'b0011);
    issue(p, 3'd4, 2'd1, 13'h000, t_p1);
    chk("R4 pre bank1 gap", t_p1, imax(t_e + 1, t_a1 + TRAS[p]));
    chk("R7 only bank1 closed", int'(b_open[p]), 1);
    chk("R9 err cleared", int'(err[p]), 0);
    issue(p, 3'd4, 2'd3, 13'h400, t_pa);
    chk("R4 pre all gap", t_pa, imax(t_p1 + 1, t_a0b + TRAS[p]));
    chk("R7 all closed", int'(b_open[p]), 0);
    chk("R7 all flag on pins", int'(c_addr[p][10]), 1);
    issue(p, 3'd5, 2'd0, 13'h000, t_ref);
    chk("R10 refresh gap", t_ref, imax(imax(t_pa + TRP[p], t_p1 + TRP[p]),
                                       imax(t_a0b + TRC[p], t_a1 + TRC[p])));
    chk("R1 refresh pins", int'(pins(p)), int'(P_REF));
    issue(p, 3'd6, 2'd0, 13'h033, t_mrs);
    chk("R10 after refresh", t_mrs - t_ref, TRC[p]);
    chk("R1 mode pins", int'(pins(p)), int'(P_MRS));
    chk("R1 mode opcode", int'(c_addr[p]), 'h033);
    issue(p, 3'd1, 2'd3, 13'h005, t_a3);
    chk("R10 after mode load", t_a3 - t_mrs, 2);
    chk("R1 bank pins", int'(c_ba[p]), 3);
    issue(p, 3'd2, 2'd3, 13'h400, t_ap);
    chk("R8 auto close wait", t_ap - t_a3, imax(TRCD[p], TRAS[p]));
    chk("R8 auto close state", int'(b_open[p]), 0);
    issue(p, 3'd1, 2'd3, 13'h006, t_x);
    chk("R8 reopen after auto close", t_x, imax(t_ap + TRP[p], t_a3 + TRC[p]));
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = 1'b0; req_op[p] = 3'd0; req_bank[p] = 2'd0; req_addr[p] = '0;
    end
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) chk("R2 deselect in reset", int'(cs_n[p]), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    for (int p = 0; p < NP; p++) begin
      chk("R2 nop after reset", int'(pins(p)), int'(P_NOP));
      chk("R2 banks closed", int'(b_open[p]), 0);
      chk("R2 err low", int'(err[p]), 0);
    end
    for (int p = 0; p < NP; p++) begin
      @(negedge clk);
      run_prof(p);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule